// File: doc/BRIEF.md
# Pipelined AES-128 Encryption Core

This block encrypts 128-bit blocks with AES-128 at a rate of one block per clock. A block enters with a valid flag and a sideband tag. The matching ciphertext leaves with the same tag exactly 31 clocks later. Any number of blocks can be in the pipeline at once, so a continuous stream of inputs gives a continuous stream of outputs.

The core does no key scheduling of its own. Software or a host expands the cipher key into eleven 128-bit round keys. The host writes each one into a register selected by index. A write is accepted only when no block is waiting at the input or moving through the pipeline. This stops a block from being encrypted with a mix of old and new round keys.

The pipeline has one input stage that adds round key 0, then ten round units of three register cuts each. Cut one is the registered substitution-table read. Cut two registers the byte permutation and column mixing; the final round has no column mixing. Cut three registers the round-key addition. Each substitution table is a 256-entry read-only memory with two read ports, and each port serves one byte of the state.

Top module: `aes128_pipe_enc`

## Requirements
- R1: A block sampled with `in_valid` high at a rising edge shows up on `out_block` with `out_valid` high after exactly 31 further rising edges, counting the sampling edge as the first. `out_valid` is low in every cycle that has no such block.
- R2: `out_block` is the AES-128 encryption of the input block under the loaded round keys. Round key 0 is added first. Rounds 1 to 9 each do substitution, row shift, column mix and key add. Round 10 leaves out the column mix. Byte 0 of the state is bits 127:120, and the bytes fill the columns in order: bytes 0 to 3 form column 0.
- R3: Blocks presented on consecutive cycles come out on consecutive cycles in the same order, with no gaps.
- R4: `out_tag` carries the `in_tag` value sampled with the block that is leaving.
- R5: A write with `key_we` high and `key_idx` from 0 to 10 loads `key_data` into that round key. It applies to every block accepted after the write.
- R6: A round-key write is ignored if `in_valid` is high in the same cycle or if any accepted block has not yet left the pipeline. Blocks already in flight keep using the keys they started with.
- R7: A write with `key_idx` from 11 to 15 changes no round key.
- R8: A synchronous reset (active-low `rst_n`) drops every block in flight, keeps `out_valid` low, and sets all round keys to zero.
- R9: With the round keys expanded from key 000102030405060708090a0b0c0d0e0f, plaintext 00112233445566778899aabbccddeeff encrypts to 69c4e0d86a7b0430d8cdb78070b4c55a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a plaintext block on `in_block` |
| in_block | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| in_tag | input | TAG_W | Sideband value carried alongside the block |
| key_we | input | 1 | Round-key write strobe |
| key_idx | input | 4 | Round-key index, 0 to 10 |
| key_data | input | 128 | Round-key value |
| out_valid | output | 1 | Marks a ciphertext block on `out_block` |
| out_block | output | 128 | Ciphertext block |
| out_tag | output | TAG_W | Tag of the ciphertext block |

## Verification
The hardest case to reach is a round-key write that arrives while the pipeline is only partly empty. Examples are the cycle in which the last block is still in the final cut, or a write in the same cycle as a new block. Only these cases show whether the idle check covers every stage. The stimulus writes keys alongside a short stream and keeps writing through the tail as the blocks drain. It then sends a fresh block and checks that no round key changed. A reset in the middle of a stream is also used, to show that in-flight blocks are dropped and that the keys return to zero.

// File: rtl/aes_pipe_pkg.sv
// Shared constants, types and GF(2^8) helpers for the pipelined AES-128 core.
// Assumes state byte i lives at bits [127-8i -: 8], column-major.
package aes_pipe_pkg;
    localparam int BLK_W  = 128;
    localparam int NB     = BLK_W / 8;
    localparam int NROUND = 10;
    localparam int CUTS   = 3;
    localparam int LAT    = 1 + NROUND * CUTS;
    localparam int NKEY   = NROUND + 1;
    localparam int KIDX_W = 4;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [7:0]       byte_t;

    // Multiply by x in GF(2^8) with the AES reduction polynomial.
    function automatic byte_t xtime(byte_t a);
        return a[7] ? byte_t'((a << 1) ^ 8'h1b) : byte_t'(a << 1);
    endfunction

    // General GF(2^8) product by shift-and-add.
    function automatic byte_t gmul(byte_t a, byte_t b);
        byte_t acc = 8'h00;
        byte_t sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (maps 0 to 0).
    function automatic byte_t ginv(byte_t a);
        byte_t r = 8'h01;
        byte_t p = a;
        byte_t e = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gmul(r, p);
            p = gmul(p, p);
        end
        return r;
    endfunction

    // Eight-bit rotate left.
    function automatic byte_t rotl8(byte_t b, int n);
        return byte_t'((b << n) | (b >> (8 - n)));
    endfunction

    // Forward substitution value: inverse followed by the affine map.
    function automatic byte_t sbox_calc(byte_t x);
        byte_t b = ginv(x);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // Row r of column c takes the byte from column (c + r) mod 4.
    function automatic blk_t shift_rows(blk_t s);
        blk_t o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[127-8*(r+4*c) -: 8] = s[127-8*(r+4*((c+r)%4)) -: 8];
        return o;
    endfunction

    // Column mixing with the fixed 2,3,1,1 circulant.
    function automatic blk_t mix_columns(blk_t s);
        blk_t  o;
        byte_t a0, a1, a2, a3;
        for (int c = 0; c < 4; c++) begin
            a0 = s[127-32*c -: 8];
            a1 = s[119-32*c -: 8];
            a2 = s[111-32*c -: 8];
            a3 = s[103-32*c -: 8];
            o[127-32*c -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
            o[119-32*c -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
            o[111-32*c -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
            o[103-32*c -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
        end
        return o;
    endfunction
endpackage

// File: rtl/aes_sbox_dp.sv
// Two-port substitution ROM: 256 bytes, one registered read per port.
// The contents are computed at elaboration, and each port serves one state byte.
module aes_sbox_dp
    import aes_pipe_pkg::*;
(
    input  logic  clk,
    input  byte_t addr_a,
    input  byte_t addr_b,
    output byte_t q_a,
    output byte_t q_b
);
    byte_t rom [256];

    // Fill the table from the substitution formula.
    initial begin
        for (int i = 0; i < 256; i++) rom[i] = sbox_calc(byte_t'(i));
    end

    // Registered reads on both ports: this is the first cut of a round.
    always_ff @(posedge clk) begin
        q_a <= rom[addr_a];
        q_b <= rom[addr_b];
    end
endmodule

// File: rtl/aes_round_stage.sv
// One AES round split into three register cuts: table read, linear layer, key add.
// FINAL drops column mixing. The round key must stay stable while blocks are in flight.
module aes_round_stage
    import aes_pipe_pkg::*;
#(
    parameter bit FINAL = 1'b0
) (
    input  logic clk,
    input  blk_t st_in,
    input  blk_t rkey,
    output blk_t st_out
);
    blk_t sub_q;
    blk_t lin_d;
    blk_t lin_q;
    blk_t ark_q;

    // Cut one: each two-port ROM handles one adjacent byte pair.
    for (genvar p = 0; p < NB/2; p++) begin : g_mem
        aes_sbox_dp u_mem (
            .clk    (clk),
            .addr_a (st_in[127-16*p -: 8]),
            .addr_b (st_in[119-16*p -: 8]),
            .q_a    (sub_q[127-16*p -: 8]),
            .q_b    (sub_q[119-16*p -: 8])
        );
    end

    // Linear layer chosen by round position.
    if (FINAL) begin : g_last
        always_comb lin_d = shift_rows(sub_q);
    end else begin : g_mid
        always_comb lin_d = mix_columns(shift_rows(sub_q));
    end

    // Cuts two and three: register linear output, then the key addition.
    always_ff @(posedge clk) begin
        lin_q <= lin_d;
        ark_q <= lin_q ^ rkey;
    end

    assign st_out = ark_q;
endmodule

// File: rtl/aes_rk_bank.sv
// Eleven round-key registers loaded by index. A write is accepted only when busy is low.
// Indices beyond the last key match no register.
module aes_rk_bank
    import aes_pipe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [KIDX_W-1:0]     idx,
    input  blk_t                  data,
    input  logic                  busy,
    output logic [NKEY*BLK_W-1:0] rk_flat
);
    for (genvar k = 0; k < NKEY; k++) begin : g_key
        // Hold one round key; clear on reset, load when addressed and idle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rk_flat[k*BLK_W +: BLK_W] <= '0;
            else if (we && !busy && idx == KIDX_W'(k))
                rk_flat[k*BLK_W +: BLK_W] <= data;
        end
    end
endmodule

// File: rtl/aes128_pipe_enc.sv
// Fully pipelined AES-128 encryption: one block per clock, fixed 31-cycle latency.
// Round keys are supplied from outside. A valid flag and a tag travel beside the data.
module aes128_pipe_enc
    import aes_pipe_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [127:0]      in_block,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              key_we,
    input  logic [3:0]        key_idx,
    input  logic [127:0]      key_data,
    output logic              out_valid,
    output logic [127:0]      out_block,
    output logic [TAG_W-1:0]  out_tag
);
    logic [NKEY*BLK_W-1:0] rk_flat;
    logic [LAT-1:0]        vpipe;
    logic [TAG_W-1:0]      tpipe [LAT];
    blk_t                  rstate [NROUND+1];
    blk_t                  st0_q;
    logic                  busy;

    // The pipeline counts as busy while a block waits at the input or is in any stage.
    assign busy = in_valid | (|vpipe);

    aes_rk_bank u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (key_we),
        .idx     (key_idx),
        .data    (key_data),
        .busy    (busy),
        .rk_flat (rk_flat)
    );

    // Input stage: register the block with round key 0 already added.
    always_ff @(posedge clk) begin
        st0_q <= in_block ^ rk_flat[0 +: BLK_W];
    end
    assign rstate[0] = st0_q;

    for (genvar r = 1; r <= NROUND; r++) begin : g_round
        aes_round_stage #(.FINAL(r == NROUND)) u_rnd (
            .clk    (clk),
            .st_in  (rstate[r-1]),
            .rkey   (rk_flat[r*BLK_W +: BLK_W]),
            .st_out (rstate[r])
        );
    end

    // Valid flag shift chain, one bit per register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    // Tag chain, same depth as the data path.
    always_ff @(posedge clk) begin
        tpipe[0] <= in_tag;
    end
    for (genvar i = 1; i < LAT; i++) begin : g_tag
        always_ff @(posedge clk) begin
            tpipe[i] <= tpipe[i-1];
        end
    end

    assign out_valid = vpipe[LAT-1];
    assign out_block = rstate[NROUND];
    assign out_tag   = tpipe[LAT-1];
endmodule

// File: rtl/aes128_pipe_chk.sv
// Protocol checker bound to the core: latency, key-write gating, reset clearing.
// Keeps its own shadow of the valid flags that have been accepted.
module aes128_pipe_chk #(
    parameter int LAT  = 31,
    parameter int NKEY = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic                 key_we,
    input logic [3:0]           key_idx,
    input logic [127:0]         key_data,
    input logic [NKEY*128-1:0]  rk_flat
);
    logic [LAT-1:0] shadow;
    logic           chk_busy;

    // Shadow record of accepted blocks, one bit per cycle of age.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else        shadow <= {shadow[LAT-2:0], in_valid};
    end
    assign chk_busy = in_valid | (|shadow);

    // R1
    lat_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == shadow[LAT-1]);

    // R6
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && chk_busy) |=> $stable(rk_flat));

    // R7
    bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_idx >= 4'(NKEY)) |=> $stable(rk_flat));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && rk_flat == '0));

    for (genvar k = 0; k < NKEY; k++) begin : g_wr
        // R5
        wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (key_we && !chk_busy && key_idx == 4'(k)) |=> rk_flat[k*128 +: 128] == $past(key_data));
    end
endmodule

bind aes128_pipe_enc aes128_pipe_chk #(
    .LAT  (aes_pipe_pkg::LAT),
    .NKEY (aes_pipe_pkg::NKEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .key_we    (key_we),
    .key_idx   (key_idx),
    .key_data  (key_data),
    .rk_flat   (rk_flat)
);

// File: tb/aes128_pipe_enc_tb.sv
// Directed bench with a ring scoreboard and an independent AES reference model.
module aes128_pipe_enc_tb;
    localparam int TW   = 8;
    localparam int LATC = 31;
    localparam int RING = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n    = 1'b0;
    logic           in_valid = 1'b0;
    logic [127:0]   in_block = '0;
    logic [TW-1:0]  in_tag   = '0;
    logic           key_we   = 1'b0;
    logic [3:0]     key_idx  = '0;
    logic [127:0]   key_data = '0;
    logic           out_valid;
    logic [127:0]   out_block;
    logic [TW-1:0]  out_tag;

    aes128_pipe_enc #(.TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
        .in_tag(in_tag), .key_we(key_we), .key_idx(key_idx), .key_data(key_data),
        .out_valid(out_valid), .out_block(out_block), .out_tag(out_tag)
    );

    logic [7:0]    sb [256];
    logic [127:0]  mk [11];
    logic [127:0]  ks [11];
    bit            ev [RING];
    logic [127:0]  ed [RING];
    logic [TW-1:0] et [RING];
    string         er [RING];
    int            cyc = 0, nchk = 0, nfail = 0, wd = 0;
    string         cur = "init";
    bit            rst_req = 1'b0;

    function automatic logic [7:0] dbl(logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    // Build the substitution table from exp/log tables and the bitwise affine rule.
    task automatic build_sbox();
        logic [7:0] ex [255];
        int         lg [256];
        logic [7:0] e = 8'h01, b;
        for (int i = 0; i < 255; i++) begin ex[i] = e; lg[e] = i; e = e ^ dbl(e); end
        for (int x = 0; x < 256; x++) begin
            b = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
            for (int i = 0; i < 8; i++)
                sb[x][i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ (8'h63 >> i);
        end
    endtask

    function automatic logic [127:0] ref_enc(logic [127:0] pt);
        logic [7:0] a [16], t [16], x0, x1, x2, x3;
        logic [127:0] o;
        for (int i = 0; i < 16; i++) a[i] = pt[127-8*i -: 8] ^ mk[0][127-8*i -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[a[i]];
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++) a[w+4*c] = t[w+4*((c+w)%4)];
            if (r < 10)
                for (int c = 0; c < 4; c++) begin
                    x0 = a[4*c]; x1 = a[4*c+1]; x2 = a[4*c+2]; x3 = a[4*c+3];
                    a[4*c]   = dbl(x0) ^ dbl(x1) ^ x1 ^ x2 ^ x3;
                    a[4*c+1] = x0 ^ dbl(x1) ^ dbl(x2) ^ x2 ^ x3;
                    a[4*c+2] = x0 ^ x1 ^ dbl(x2) ^ dbl(x3) ^ x3;
                    a[4*c+3] = dbl(x0) ^ x0 ^ x1 ^ x2 ^ dbl(x3);
                end
            for (int i = 0; i < 16; i++) a[i] = a[i] ^ mk[r][127-8*i -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = a[i];
        return o;
    endfunction

    // Expand a cipher key into ks[0..10].
    task automatic expand(logic [127:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
                rc = dbl(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int k = 0; k < 11; k++) ks[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // One cycle: check the output slot, update the model, drive the next inputs.
    task automatic tick(bit v, logic [127:0] pt, logic [TW-1:0] tg,
                        bit kwe, logic [3:0] kidx, logic [127:0] kd);
        int s;
        bit busy;
        @(negedge clk);
        s = cyc % RING;
        if (rst_n && (ev[s] || out_valid === 1'b1)) begin
            nchk++;
            if (out_valid !== ev[s] || (ev[s] && (out_block !== ed[s] || out_tag !== et[s]))) begin
                nfail++;
                $display("FAIL %s: got valid=%0b data=%h tag=%h, expected valid=%0b data=%h tag=%h",
                         ev[s] ? er[s] : cur, out_valid, out_block, out_tag, ev[s], ed[s], et[s]);
            end
        end
        busy = v;
        for (int k = 0; k < LATC; k++) busy |= ev[(cyc + k) % RING];
        ev[s] = 1'b0;
        rst_n = !rst_req;
        if (rst_req) begin
            for (int k = 0; k < RING; k++) ev[k] = 1'b0;
            for (int k = 0; k < 11; k++) mk[k] = '0;
        end else if (kwe && !busy && kidx <= 4'd10) begin
            mk[kidx] = kd;
        end
        in_valid = v; in_block = pt; in_tag = tg;
        key_we = kwe; key_idx = kidx; key_data = kd;
        s = (cyc + LATC) % RING;
        ev[s] = v && !rst_req; ed[s] = ref_enc(pt); et[s] = tg; er[s] = cur;
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, '0, 1'b0, 4'd0, '0);
    endtask
    task automatic send(logic [127:0] pt, logic [TW-1:0] tg);
        tick(1'b1, pt, tg, 1'b0, 4'd0, '0);
    endtask
    task automatic load_keys(logic [127:0] key);
        expand(key);
        for (int k = 0; k < 11; k++) tick(1'b0, '0, '0, 1'b1, 4'(k), ks[k]);
    endtask
    task automatic drain();
        idle(LATC + 2);
    endtask

    // R8: reset state; zero keys afterwards.
    task automatic test_reset();
        cur = "R8 reset state";
        rst_req = 1'b1; idle(3); rst_req = 1'b0; idle(2);
        nchk++;
        if (out_valid !== 1'b0) begin
            nfail++; $display("FAIL R8: out_valid=%b expected 0 after reset", out_valid);
        end
        send(rnd128(), 8'h11);
        drain();
    endtask

    // R9 R2 R1: known-answer block under the expanded reference key.
    task automatic test_kat();
        logic [127:0] exp_ct = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
        cur = "R9 known answer";
        load_keys(128'h000102030405060708090a0b0c0d0e0f);
        nchk++;
        if (ref_enc(128'h00112233445566778899aabbccddeeff) !== exp_ct) begin
            nfail++; $display("FAIL R9: model gives %h expected %h",
                              ref_enc(128'h00112233445566778899aabbccddeeff), exp_ct);
        end
        send(128'h00112233445566778899aabbccddeeff, 8'h5a);
        drain();
    endtask

    // R3 R4 R2: back-to-back stream with per-block tags.
    task automatic test_stream();
        cur = "R3 R4 back-to-back";
        for (int i = 0; i < 40; i++) send(rnd128(), TW'(i));
        drain();
    endtask

    // R1 R4: sparse pattern to pin the latency.
    task automatic test_gaps();
        cur = "R1 R4 sparse";
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 0) send(rnd128(), TW'($urandom));
            else            idle(1);
        end
        drain();
    endtask

    // R6: writes attempted with blocks entering and draining.
    task automatic test_busy_write();
        cur = "R6 write while busy";
        for (int i = 0; i < 5; i++) tick(1'b1, rnd128(), TW'(i), 1'b1, 4'd3, rnd128());
        for (int i = 0; i < LATC; i++) tick(1'b0, '0, '0, 1'b1, 4'(i % 11), rnd128());
        send(rnd128(), 8'hb6);
        drain();
    endtask

    // R7: out-of-range indices leave keys intact.
    task automatic test_bad_idx();
        cur = "R7 bad index";
        tick(1'b0, '0, '0, 1'b1, 4'd11, rnd128());
        tick(1'b0, '0, '0, 1'b1, 4'd15, rnd128());
        send(rnd128(), 8'h77);
        drain();
    endtask

    // R5: new key set, then single-key overwrite.
    task automatic test_rekey();
        cur = "R5 reload keys";
        load_keys(rnd128());
        for (int i = 0; i < 10; i++) send(rnd128(), TW'(i + 100));
        drain();
        tick(1'b0, '0, '0, 1'b1, 4'd10, rnd128());
        send(rnd128(), 8'h3c);
        drain();
    endtask

    // R8: reset with blocks in flight drops them and clears keys.
    task automatic test_mid_reset();
        cur = "R8 reset mid-flight";
        for (int i = 0; i < 8; i++) send(rnd128(), TW'(i));
        idle(5);
        rst_req = 1'b1; idle(2); rst_req = 1'b0;
        idle(LATC + 2);
        send(rnd128(), 8'h99);
        drain();
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            nfail++;
            $display("FAIL watchdog: run exceeded cycle limit in %s", cur);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        build_sbox();
        for (int k = 0; k < 11; k++) mk[k] = '0;
        for (int k = 0; k < RING; k++) ev[k] = 1'b0;
        test_reset();
        test_kat();
        test_stream();
        test_gaps();
        test_busy_write();
        test_bad_idx();
        test_rekey();
        test_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule